// File: doc/BRIEF.md
# Power Manager Supervisory State Machine

This block is the top-level controller of a multi-rail power management unit. It watches the input-supply-valid comparator, the die temperature trip, and per-rail overvoltage and undervoltage comparators. It then decides whether the regulators run, sleep or shut down. It drives one enable per regulator, three active-low reset outputs, a one-cycle request that starts the programmed power-up sequencer, and a gate for the register bus. It also reports thermal and OV/UV status flags, and these flags stay live while the matching fault state is masked.

A rail fault shuts every regulator off and starts a retry timer. When the timer expires, the machine tries ACTIVE again. If the fault is still present, the machine falls straight back into the fault state, and this repeats until the fault clears or the supply drops. The low-power SLEEP state can be requested either by a falling edge on the power-enable pin or by a register write. The register path is disabled while asleep, so only a pin edge can wake the block.

The retry period is a cycle-count parameter. Its default gives 100 ms at a 125 MHz clock.

Top module: `pwr_supervisor`

## Requirements
- R1: When `vin_ok` is low at a clock edge, the state becomes RESET (code 0) at that edge, from any state. RESET is left for ACTIVE at the first edge at which `vin_ok` is high, unless a higher-priority condition applies.
- R2: `seq_start` is high for exactly the first cycle of ACTIVE after entry from RESET, THERMAL or FAULT. It stays low when ACTIVE is entered from SLEEP.
- R3: Sleep request in ACTIVE:
  - When `cfg_pd_mode`=0, the request is a synchronised falling edge of `pwr_en_pin`. A rising edge is ignored.
  - When `cfg_pd_mode`=1 and `cfg_pd_en`=1, the request is a one-cycle `sleep_wr` pulse.
  - `sleep_wr` is ignored when `cfg_pd_en`=0 or when `cfg_pd_mode`=0.
- R4: In SLEEP (code 2), `i2c_en`=0, `rail_en` equals `cfg_sleep_on`, all reset outputs are high, and `sleep_wr` is ignored. SLEEP is left for ACTIVE only after a rising or falling edge of `pwr_en_pin`, passed through a two-flop synchroniser.
- R5: With `cfg_tsd_mask_n`=1, a high `tsd_flag` moves the state to THERMAL (code 3). In THERMAL all `rail_en` bits are 0 and all `rst_out_n` bits are 0. When `tsd_flag` clears, the state moves to ACTIVE. With `cfg_tsd_mask_n`=0, THERMAL is never entered, yet `tsd_stat` still follows `tsd_flag`.
- R6: An overvoltage on any rail is a fault at any time. An undervoltage on rail i is a fault only while `ss_done[i]`=1.
- R7: A qualified OV/UV fault moves the state to FAULT (code 4). In FAULT all rails are off and all reset outputs are low. The state stays FAULT for exactly RETRY_CYCLES cycles and then enters ACTIVE. If the fault persists, the state re-enters FAULT one cycle later.
- R8: `cfg_ov_mask_n`=0 stops OV from causing FAULT, and `cfg_uv_mask_n`=0 stops UV from causing FAULT. `ovuv_stat` still reports the unmasked condition (OV on any rail, or UV on a rail whose soft-start is done).
- R9: When several conditions hold at once, they are served in this order: low input supply, then thermal, then OV/UV, then sleep request.
- R10: In ACTIVE (code 1), every `rail_en` bit is 1, every `rst_out_n` bit is 1, and `i2c_en` is 1.
- R11: While `rst_n` is low, the state is RESET, `rail_en`=0, `rst_out_n`=0 and `seq_start`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input supply above the UVLO threshold |
| tsd_flag | input | 1 | Thermal shutdown comparator |
| ov_flag | input | N_RAILS | Per-rail overvoltage |
| uv_flag | input | N_RAILS | Per-rail undervoltage |
| ss_done | input | N_RAILS | Per-rail soft-start complete |
| pwr_en_pin | input | 1 | Asynchronous power-enable pin |
| cfg_tsd_mask_n | input | 1 | 1 enables the THERMAL state |
| cfg_ov_mask_n | input | 1 | 1 lets OV enter FAULT |
| cfg_uv_mask_n | input | 1 | 1 lets UV enter FAULT |
| cfg_pd_mode | input | 1 | 0 selects the pin sleep path, 1 selects the register sleep path |
| cfg_pd_en | input | 1 | Arms the register sleep path |
| cfg_sleep_on | input | N_RAILS | Per-rail enable while in SLEEP |
| sleep_wr | input | 1 | One-cycle register command to enter SLEEP |
| state_o | output | 3 | Current state code |
| rail_en | output | N_RAILS | Regulator enables |
| seq_start | output | 1 | Request for a sequenced power-up |
| rst_out_n | output | N_RST | Active-low reset outputs |
| i2c_en | output | 1 | Register bus enable |
| tsd_stat | output | 1 | Thermal status, independent of the mask |
| ovuv_stat | output | 1 | OV/UV status, independent of the masks |

## Verification
The bench sweeps every rail through each combination of soft-start-done and mask. A design that counted undervoltage during the soft-start ramp, or that let a mask also silence the status flag, would show the wrong state or a wrong `ovuv_stat`.

The retry dwell is measured to the exact cycle, including the one-cycle ACTIVE probe inside a persistent fault loop. An off-by-one counter would move the return edge.

Simultaneous conditions are driven together to expose a wrong priority order. Sleep is entered and left through both paths, which catches a wake-up that wrongly pulses the sequencer or a register write that still acts while asleep.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

  typedef enum logic [2:0] {
    ST_RESET   = 3'd0,
    ST_ACTIVE  = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_THERMAL = 3'd3,
    ST_FAULT   = 3'd4
  } pwr_state_e;

  // States in which all rails are off, so returning to ACTIVE needs sequencing
  function automatic logic rails_down(input pwr_state_e s);
    return (s == ST_RESET) || (s == ST_THERMAL) || (s == ST_FAULT);
  endfunction

  // Rails qualified for undervoltage: only those past soft-start
  function automatic logic uv_counts(input logic uv, input logic ss);
    return uv & ss;
  endfunction

endpackage

// File: rtl/pwr_pin_sync.sv
module pwr_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_fall,
  output logic pin_edge
);
  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign pin_fall = hist_q & ~sync_q;
  assign pin_edge = hist_q ^ sync_q;
endmodule

// File: rtl/pwr_fault_detect.sv
module pwr_fault_detect #(
  parameter int N_RAILS = 4
) (
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] uv_flag,
  input  logic [N_RAILS-1:0] ss_done,
  input  logic               ov_mask_n,
  input  logic               uv_mask_n,
  output logic               ovuv_raw,
  output logic               ovuv_trip
);
  import pwr_sup_pkg::*;

  logic [N_RAILS-1:0] uv_qual;

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign uv_qual[g] = uv_counts(uv_flag[g], ss_done[g]);
  end

  logic ov_any, uv_any;
  assign ov_any    = |ov_flag;
  assign uv_any    = |uv_qual;
  assign ovuv_raw  = ov_any | uv_any;
  assign ovuv_trip = (ov_any & ov_mask_n) | (uv_any & uv_mask_n);
endmodule

// File: rtl/pwr_retry_timer.sv
module pwr_retry_timer #(
  parameter int RETRY_CYCLES = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(RETRY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RETRY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
  parameter int N_RAILS      = 4,
  parameter int N_RST        = 3,
  parameter int RETRY_CYCLES = 12_500_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vin_ok,
  input  logic               tsd_flag,
  input  logic [N_RAILS-1:0] ov_flag,
  input  logic [N_RAILS-1:0] uv_flag,
  input  logic [N_RAILS-1:0] ss_done,
  input  logic               pwr_en_pin,
  input  logic               cfg_tsd_mask_n,
  input  logic               cfg_ov_mask_n,
  input  logic               cfg_uv_mask_n,
  input  logic               cfg_pd_mode,
  input  logic               cfg_pd_en,
  input  logic [N_RAILS-1:0] cfg_sleep_on,
  input  logic               sleep_wr,
  output logic [2:0]         state_o,
  output logic [N_RAILS-1:0] rail_en,
  output logic               seq_start,
  output logic [N_RST-1:0]   rst_out_n,
  output logic               i2c_en,
  output logic               tsd_stat,
  output logic               ovuv_stat
);
  import pwr_sup_pkg::*;

  pwr_state_e state_q, state_d;
  logic pin_fall, pin_edge;
  logic ovuv_raw, ovuv_trip, tsd_trip;
  logic retry_expire, sleep_req, seq_q;

  pwr_pin_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pwr_en_pin),
    .pin_fall  (pin_fall),
    .pin_edge  (pin_edge)
  );

  pwr_fault_detect #(.N_RAILS(N_RAILS)) u_fault (
    .ov_flag   (ov_flag),
    .uv_flag   (uv_flag),
    .ss_done   (ss_done),
    .ov_mask_n (cfg_ov_mask_n),
    .uv_mask_n (cfg_uv_mask_n),
    .ovuv_raw  (ovuv_raw),
    .ovuv_trip (ovuv_trip)
  );

  pwr_retry_timer #(.RETRY_CYCLES(RETRY_CYCLES)) u_retry (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state_q == ST_FAULT),
    .expire (retry_expire)
  );

  assign tsd_trip  = tsd_flag & cfg_tsd_mask_n;
  assign sleep_req = cfg_pd_mode ? (cfg_pd_en & sleep_wr & i2c_en) : pin_fall;

  always_comb begin
    state_d = state_q;
    if (!vin_ok)                              state_d = ST_RESET;
    else if (tsd_trip)                        state_d = ST_THERMAL;
    else if (ovuv_trip && state_q != ST_FAULT) state_d = ST_FAULT;
    else begin
      unique case (state_q)
        ST_RESET:   state_d = ST_ACTIVE;
        ST_THERMAL: state_d = ST_ACTIVE;
        ST_FAULT:   state_d = retry_expire ? ST_ACTIVE : ST_FAULT;
        ST_ACTIVE:  state_d = sleep_req ? ST_SLEEP : ST_ACTIVE;
        ST_SLEEP:   state_d = pin_edge ? ST_ACTIVE : ST_SLEEP;
        default:    state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RESET;
      seq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      seq_q   <= (state_d == ST_ACTIVE) && rails_down(state_q);
    end
  end

  always_comb begin
    unique case (state_q)
      ST_ACTIVE: rail_en = '1;
      ST_SLEEP:  rail_en = cfg_sleep_on;
      default:   rail_en = '0;
    endcase
  end

  assign rst_out_n = {N_RST{(state_q == ST_ACTIVE) || (state_q == ST_SLEEP)}};
  assign i2c_en    = (state_q != ST_SLEEP);
  assign seq_start = seq_q;
  assign state_o   = state_q;
  assign tsd_stat  = tsd_flag;
  assign ovuv_stat = ovuv_raw;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
  parameter int N_RAILS      = 4,
  parameter int N_RST        = 3,
  parameter int RETRY_CYCLES = 12_500_000
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vin_ok,
  input logic               cfg_tsd_mask_n,
  input logic [2:0]         state_o,
  input logic [N_RAILS-1:0] rail_en,
  input logic [N_RST-1:0]   rst_out_n,
  input logic               i2c_en,
  input logic               seq_start,
  input logic               pin_edge
);
  import pwr_sup_pkg::*;

  int unsigned dwell_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dwell_q <= 0;
    else if (state_o == ST_FAULT) dwell_q <= dwell_q + 1;
    else                        dwell_q <= 0;
  end

  AST_UVLO_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !vin_ok |=> state_o == ST_RESET); // R1
  AST_NO_SEQ_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_ACTIVE && $past(state_o) == ST_SLEEP) |-> !seq_start); // R2
  AST_SLEEP_BUS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_SLEEP |-> !i2c_en); // R4
  AST_SLEEP_EXIT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_SLEEP && state_o == ST_ACTIVE) |-> $past(pin_edge)); // R4
  AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_THERMAL |-> (rail_en == '0 && rst_out_n == '0)); // R5
  AST_THERMAL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_tsd_mask_n && state_o != ST_THERMAL) |=> state_o != ST_THERMAL); // R5
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_FAULT |-> (rail_en == '0 && rst_out_n == '0)); // R7
  AST_RETRY_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == ST_FAULT && state_o == ST_ACTIVE) |-> $past(dwell_q) == RETRY_CYCLES - 1); // R7
  AST_ACTIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_ACTIVE |-> (rail_en == '1 && rst_out_n == '1 && i2c_en)); // R10
endmodule

bind pwr_supervisor pwr_supervisor_chk #(
  .N_RAILS(N_RAILS), .N_RST(N_RST), .RETRY_CYCLES(RETRY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .cfg_tsd_mask_n(cfg_tsd_mask_n),
  .state_o(state_o), .rail_en(rail_en), .rst_out_n(rst_out_n), .i2c_en(i2c_en),
  .seq_start(seq_start), .pin_edge(pin_edge)
);

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;
  localparam int NR = 4;
  localparam int RC = 20;
  localparam logic [2:0] S_RESET = 3'd0, S_ACT = 3'd1, S_SLP = 3'd2, S_THM = 3'd3, S_FLT = 3'd4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vin_ok = 1'b0, tsd_flag = 1'b0, pwr_en_pin = 1'b1;
  logic [NR-1:0] ov_flag = '0, uv_flag = '0, ss_done = '0, cfg_sleep_on = 4'b0101;
  logic cfg_tsd_mask_n = 1'b1, cfg_ov_mask_n = 1'b1, cfg_uv_mask_n = 1'b1;
  logic cfg_pd_mode = 1'b1, cfg_pd_en = 1'b0, sleep_wr = 1'b0;
  logic [2:0] state_o;
  logic [NR-1:0] rail_en;
  logic seq_start, i2c_en, tsd_stat, ovuv_stat;
  logic [2:0] rst_out_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pwr_supervisor #(.N_RAILS(NR), .N_RST(3), .RETRY_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .tsd_flag(tsd_flag),
    .ov_flag(ov_flag), .uv_flag(uv_flag), .ss_done(ss_done), .pwr_en_pin(pwr_en_pin),
    .cfg_tsd_mask_n(cfg_tsd_mask_n), .cfg_ov_mask_n(cfg_ov_mask_n), .cfg_uv_mask_n(cfg_uv_mask_n),
    .cfg_pd_mode(cfg_pd_mode), .cfg_pd_en(cfg_pd_en), .cfg_sleep_on(cfg_sleep_on),
    .sleep_wr(sleep_wr), .state_o(state_o), .rail_en(rail_en), .seq_start(seq_start),
    .rst_out_n(rst_out_n), .i2c_en(i2c_en), .tsd_stat(tsd_stat), .ovuv_stat(ovuv_stat)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at the negedge right after FAULT was entered, with the fault removed
  task automatic recover(input string tag);
    step(RC - 1);
    check({tag, " R7 still in fault"}, 32'(state_o), 32'(S_FLT));
    step(1);
    check({tag, " R7 retry to active"}, 32'(state_o), 32'(S_ACT));
    check({tag, " R2 seq after retry"}, 32'(seq_start), 32'd1);
    step(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R11 reset state
    step(2);
    check("R11 state", 32'(state_o), 32'(S_RESET));
    check("R11 rails", 32'(rail_en), 32'd0);
    check("R11 resets", 32'(rst_out_n), 32'd0);
    check("R11 seq", 32'(seq_start), 32'd0);
    rst_n = 1'b1;
    step(3);
    check("R1 held in reset by low vin", 32'(state_o), 32'(S_RESET));
    vin_ok = 1'b1;
    step(1);
    check("R1 leave reset", 32'(state_o), 32'(S_ACT));
    check("R2 seq pulse", 32'(seq_start), 32'd1);
    check("R10 rails on", 32'(rail_en), 32'hF);
    check("R10 resets high", 32'(rst_out_n), 32'h7);
    check("R10 bus on", 32'(i2c_en), 32'd1);
    step(1);
    check("R2 seq one cycle", 32'(seq_start), 32'd0);

    // R6/R8 undervoltage sweep
    for (int r = 0; r < NR; r++)
      for (int ss = 0; ss < 2; ss++)
        for (int m = 0; m < 2; m++) begin
          uv_flag = '0; uv_flag[r] = 1'b1;
          ss_done = '0; ss_done[r] = ss[0];
          cfg_uv_mask_n = m[0];
          #1;
          check("R8 uv status", 32'(ovuv_stat), 32'(ss));
          step(1);
          check("R6 uv gating", 32'(state_o), (ss == 1 && m == 1) ? 32'(S_FLT) : 32'(S_ACT));
          uv_flag = '0; ss_done = '0;
          if (ss == 1 && m == 1) recover("uv");
        end
    cfg_uv_mask_n = 1'b1;

    // R6/R8 overvoltage sweep, soft-start not done
    for (int r = 0; r < NR; r++)
      for (int m = 0; m < 2; m++) begin
        ov_flag = '0; ov_flag[r] = 1'b1;
        cfg_ov_mask_n = m[0];
        #1;
        check("R8 ov status", 32'(ovuv_stat), 32'd1);
        step(1);
        check("R6 ov any time", 32'(state_o), m ? 32'(S_FLT) : 32'(S_ACT));
        ov_flag = '0;
        if (m == 1) recover("ov");
      end

    // R7 persistent fault loops
    ov_flag[2] = 1'b1;
    step(1);
    check("R7 enter", 32'(state_o), 32'(S_FLT));
    check("R7 rails off", 32'(rail_en), 32'd0);
    check("R7 resets low", 32'(rst_out_n), 32'd0);
    step(RC);
    check("R7 retry probe", 32'(state_o), 32'(S_ACT));
    step(1);
    check("R7 re-enter", 32'(state_o), 32'(S_FLT));
    ov_flag = '0;
    recover("loop");

    // R5 thermal
    tsd_flag = 1'b1;
    step(1);
    check("R5 thermal", 32'(state_o), 32'(S_THM));
    check("R5 rails off", 32'(rail_en), 32'd0);
    check("R5 resets low", 32'(rst_out_n), 32'd0);
    tsd_flag = 1'b0;
    step(1);
    check("R5 thermal exit", 32'(state_o), 32'(S_ACT));
    check("R2 seq after thermal", 32'(seq_start), 32'd1);
    cfg_tsd_mask_n = 1'b0; tsd_flag = 1'b1;
    step(3);
    check("R5 masked stays active", 32'(state_o), 32'(S_ACT));
    check("R5 status live", 32'(tsd_stat), 32'd1);
    tsd_flag = 1'b0; cfg_tsd_mask_n = 1'b1;

    // R9 priority
    tsd_flag = 1'b1; ov_flag = 4'b0001;
    step(1);
    check("R9 thermal over ovuv", 32'(state_o), 32'(S_THM));
    vin_ok = 1'b0;
    step(1);
    check("R9 uvlo over thermal", 32'(state_o), 32'(S_RESET));
    tsd_flag = 1'b0; ov_flag = '0; vin_ok = 1'b1;
    step(2);
    cfg_pd_en = 1'b1; sleep_wr = 1'b1; ov_flag = 4'b1000;
    step(1);
    check("R9 ovuv over sleep", 32'(state_o), 32'(S_FLT));
    sleep_wr = 1'b0; ov_flag = '0;
    recover("prio");

    // R3/R4 register sleep path
    cfg_pd_en = 1'b0; sleep_wr = 1'b1;
    step(1); sleep_wr = 1'b0; step(1);
    check("R3 write ignored unarmed", 32'(state_o), 32'(S_ACT));
    cfg_pd_en = 1'b1; sleep_wr = 1'b1;
    step(1); sleep_wr = 1'b0;
    check("R3 write enters sleep", 32'(state_o), 32'(S_SLP));
    check("R4 bus off", 32'(i2c_en), 32'd0);
    check("R4 sleep rails", 32'(rail_en), 32'h5);
    check("R4 resets high", 32'(rst_out_n), 32'h7);
    sleep_wr = 1'b1; step(1); sleep_wr = 1'b0; step(4);
    check("R4 stays asleep", 32'(state_o), 32'(S_SLP));
    pwr_en_pin = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 5; i++) begin step(1); if (seq_start) seen = 1'b1; end
    check("R4 pin wakes", 32'(state_o), 32'(S_ACT));
    check("R2 no seq from sleep", 32'(seen), 32'd0);

    // R3 pin sleep path
    cfg_pd_mode = 1'b0;
    pwr_en_pin = 1'b1; step(5);
    check("R3 rising ignored", 32'(state_o), 32'(S_ACT));
    sleep_wr = 1'b1; step(1); sleep_wr = 1'b0; step(2);
    check("R3 write ignored in pin mode", 32'(state_o), 32'(S_ACT));
    pwr_en_pin = 1'b0; step(5);
    check("R3 falling enters sleep", 32'(state_o), 32'(S_SLP));
    pwr_en_pin = 1'b1; step(5);
    check("R4 rising wakes", 32'(state_o), 32'(S_ACT));

    // R1 from sleep
    pwr_en_pin = 1'b0; step(5);
    check("R3 sleep again", 32'(state_o), 32'(S_SLP));
    vin_ok = 1'b0; step(1);
    check("R1 uvlo from sleep", 32'(state_o), 32'(S_RESET));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule